// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a 20-bit physical memory address for a real-mode segmented processor. For data accesses it receives an addressing-mode code, the base, index and pointer register values, a 16-bit two's-complement displacement and the four segment register values. From these it forms the effective offset, picks the segment the mode implies, and adds the segment value shifted left by four bits. An instruction-fetch request takes priority over everything else and always forms its address from the code segment and the instruction pointer.

An optional override request replaces the implied segment for data accesses. Register and immediate operands reach no memory, and the block flags them with a dedicated output. Both outputs are registered and follow their inputs one clock later. Instruction decoding, register storage and bus sequencing stay in neighbouring blocks.

Top module: `seg_addr_gen`

## Requirements
- R1: One clock after the inputs are presented, addr_o equals (segment * 16 + effective offset) modulo 2^20.
- R2: A sum above FFFFFh wraps into low memory: code segment FF59h with instruction pointer FFFFh gives 0F58Fh.
- R3: While fetch_i is 1, the address is formed from cs_i:ip_i. mode_i and the override inputs are ignored, and no_mem_o is 0.
- R4: Mode 010 (direct) uses disp_i as the offset and the data segment by default.
- R5: Mode 011 (register indirect) uses no displacement. ptr_sel_i picks the offset register: 00 BX, 01 SI, 10 DI, 11 BX. The data segment is the default.
- R6: Mode 100 (based) uses base + disp_i. base_sel_i 0 picks BX with the data segment; 1 picks BP with the stack segment.
- R7: Mode 101 (indexed) uses index + disp_i with the data segment. idx_sel_i 0 picks SI; 1 picks DI.
- R8: Mode 110 (based indexed) uses base + index + disp_i. The segment follows the base register as in R6.
- R9: The effective offset is reduced modulo 2^16 before the segment is added.
- R10: For data accesses, ovr_en_i 1 replaces the default segment by ovr_sel_i: 00 ES, 01 CS, 10 SS, 11 DS.
- R11: Modes 000 (register), 001 (immediate) and 111 (reserved) without fetch_i set no_mem_o to 1 one clock later. In those cases addr_o is don't-care. Modes 010 to 110 set no_mem_o to 0.
- R12: While rst_ni is 0, addr_o is 0 and no_mem_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_i | input | 1 | Instruction-fetch request, uses CS:IP |
| mode_i | input | 3 | Addressing-mode code |
| base_sel_i | input | 1 | Base register select: 0 BX, 1 BP |
| idx_sel_i | input | 1 | Index register select: 0 SI, 1 DI |
| ptr_sel_i | input | 2 | Register-indirect pointer select |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| disp_i | input | 16 | Displacement, two's complement |
| ovr_en_i | input | 1 | Segment override request |
| ovr_sel_i | input | 2 | Override segment select |
| cs_i | input | 16 | Code segment |
| ds_i | input | 16 | Data segment |
| ss_i | input | 16 | Stack segment |
| es_i | input | 16 | Extra segment |
| ip_i | input | 16 | Instruction pointer |
| addr_o | output | 20 | Registered physical address |
| no_mem_o | output | 1 | Registered flag: operand needs no memory access |

## Verification
All segment registers are loaded with distinct values, so each test shows which segment was picked. Directed cases cover:
- fetch combined with an override and a register mode, which shows that fetch has priority;
- each override code;
- a BP base against a BX base, which shows the stack-segment default;
- offsets that overflow 16 bits and sums that overflow 20 bits, which separate the two wrap points.

Seeded random vectors over every mode and selector then compare the address and the no-memory flag with a model built from the requirements.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  parameter int unsigned OFS_W     = 16;
  parameter int unsigned SEG_SHIFT = 4;
  localparam int unsigned ADDR_W   = OFS_W + SEG_SHIFT;

  typedef enum logic [2:0] {
    AM_REG       = 3'd0,
    AM_IMM       = 3'd1,
    AM_DIRECT    = 3'd2,
    AM_REG_IND   = 3'd3,
    AM_BASED     = 3'd4,
    AM_INDEXED   = 3'd5,
    AM_BASED_IDX = 3'd6,
    AM_RSVD      = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;
endpackage

// File: rtl/seg_ea_calc.sv
module seg_ea_calc
  import seg_addr_pkg::*;
#(
  parameter int unsigned W = OFS_W
) (
  input  amode_e         mode_i,
  input  logic           base_sel_i,
  input  logic           idx_sel_i,
  input  logic [1:0]     ptr_sel_i,
  input  logic [W-1:0]   bx_i,
  input  logic [W-1:0]   bp_i,
  input  logic [W-1:0]   si_i,
  input  logic [W-1:0]   di_i,
  input  logic [W-1:0]   disp_i,
  output logic [W-1:0]   ofs_o,
  output logic           uses_bp_o,
  output logic           mem_ref_o
);
  logic [W-1:0] base_val, idx_val, ptr_val;

  always_comb begin
    base_val = base_sel_i ? bp_i : bx_i;
    idx_val  = idx_sel_i  ? di_i : si_i;
    unique case (ptr_sel_i)
      2'b01:   ptr_val = si_i;
      2'b10:   ptr_val = di_i;
      default: ptr_val = bx_i;
    endcase
  end

  // sums truncate to W bits: offset wraps modulo 2^W
  always_comb begin
    ofs_o     = '0;
    mem_ref_o = 1'b1;
    unique case (mode_i)
      AM_DIRECT:    ofs_o = disp_i;
      AM_REG_IND:   ofs_o = ptr_val;
      AM_BASED:     ofs_o = base_val + disp_i;
      AM_INDEXED:   ofs_o = idx_val + disp_i;
      AM_BASED_IDX: ofs_o = base_val + idx_val + disp_i;
      default:      mem_ref_o = 1'b0;
    endcase
    uses_bp_o = base_sel_i && (mode_i == AM_BASED || mode_i == AM_BASED_IDX);
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int unsigned W = OFS_W
) (
  input  logic         fetch_i,
  input  logic         ovr_en_i,
  input  seg_e         ovr_sel_i,
  input  logic         uses_bp_i,
  input  logic [W-1:0] cs_i,
  input  logic [W-1:0] ds_i,
  input  logic [W-1:0] ss_i,
  input  logic [W-1:0] es_i,
  output logic [W-1:0] seg_o
);
  seg_e pick;

  always_comb begin
    if (fetch_i)       pick = SEG_CS;
    else if (ovr_en_i) pick = ovr_sel_i;
    else if (uses_bp_i) pick = SEG_SS;
    else               pick = SEG_DS;

    unique case (pick)
      SEG_ES:  seg_o = es_i;
      SEG_CS:  seg_o = cs_i;
      SEG_SS:  seg_o = ss_i;
      default: seg_o = ds_i;
    endcase
  end
endmodule

// File: rtl/seg_phys_add.sv
module seg_phys_add
  import seg_addr_pkg::*;
#(
  parameter int unsigned W     = OFS_W,
  parameter int unsigned SHIFT = SEG_SHIFT,
  localparam int unsigned AW   = W + SHIFT
) (
  input  logic [W-1:0]  seg_i,
  input  logic [W-1:0]  ofs_i,
  output logic [AW-1:0] addr_o
);
  // carry beyond AW bits is dropped: wrap modulo 2^AW
  assign addr_o = {seg_i, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, ofs_i};
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned W     = OFS_W,
  parameter int unsigned SHIFT = SEG_SHIFT,
  localparam int unsigned AW   = W + SHIFT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_i,
  input  logic [2:0]    mode_i,
  input  logic          base_sel_i,
  input  logic          idx_sel_i,
  input  logic [1:0]    ptr_sel_i,
  input  logic [W-1:0]  bx_i,
  input  logic [W-1:0]  bp_i,
  input  logic [W-1:0]  si_i,
  input  logic [W-1:0]  di_i,
  input  logic [W-1:0]  disp_i,
  input  logic          ovr_en_i,
  input  logic [1:0]    ovr_sel_i,
  input  logic [W-1:0]  cs_i,
  input  logic [W-1:0]  ds_i,
  input  logic [W-1:0]  ss_i,
  input  logic [W-1:0]  es_i,
  input  logic [W-1:0]  ip_i,
  output logic [AW-1:0] addr_o,
  output logic          no_mem_o
);
  logic [W-1:0]  ea_ofs, ofs, seg;
  logic [AW-1:0] addr_d;
  logic          uses_bp, mem_ref;

  seg_ea_calc #(.W(W)) i_ea (
    .mode_i    (amode_e'(mode_i)),
    .base_sel_i(base_sel_i),
    .idx_sel_i (idx_sel_i),
    .ptr_sel_i (ptr_sel_i),
    .bx_i      (bx_i),
    .bp_i      (bp_i),
    .si_i      (si_i),
    .di_i      (di_i),
    .disp_i    (disp_i),
    .ofs_o     (ea_ofs),
    .uses_bp_o (uses_bp),
    .mem_ref_o (mem_ref)
  );

  seg_select #(.W(W)) i_sel (
    .fetch_i  (fetch_i),
    .ovr_en_i (ovr_en_i),
    .ovr_sel_i(seg_e'(ovr_sel_i)),
    .uses_bp_i(uses_bp),
    .cs_i     (cs_i),
    .ds_i     (ds_i),
    .ss_i     (ss_i),
    .es_i     (es_i),
    .seg_o    (seg)
  );

  assign ofs = fetch_i ? ip_i : ea_ofs;

  seg_phys_add #(.W(W), .SHIFT(SHIFT)) i_add (
    .seg_i (seg),
    .ofs_i (ofs),
    .addr_o(addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      no_mem_o <= 1'b1;
    end else begin
      addr_o   <= addr_d;
      no_mem_o <= !(fetch_i || mem_ref);
    end
  end

  // one-cycle history is valid only after the first clock out of reset
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(fetch_i && cs_i == 16'hFF59 && ip_i == 16'hFFFF)
      |-> addr_o == 20'h0F58F);

  assert_fetch_mem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(fetch_i) |-> !no_mem_o);

  assert_no_mem_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!fetch_i && (mode_i == 3'd0 || mode_i == 3'd1 || mode_i == 3'd7))
      |-> no_mem_o);

  assert_bp_stack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!fetch_i && !ovr_en_i && mode_i == 3'd4 && base_sel_i
                     && bp_i == '0 && disp_i == '0)
      |-> addr_o == $past({ss_i, {SHIFT{1'b0}}}));

  assert_direct_ds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!fetch_i && !ovr_en_i && mode_i == 3'd2 && disp_i == '0)
      |-> addr_o == $past({ds_i, {SHIFT{1'b0}}}));
endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch = 1'b0;
  logic [2:0]  mode = '0;
  logic        base_sel = 1'b0, idx_sel = 1'b0;
  logic [1:0]  ptr_sel = '0;
  logic [15:0] bx = '0, bp = '0, si = '0, di = '0, disp = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic [15:0] cs = '0, ds = '0, ss = '0, es = '0, ip = '0;
  logic [19:0] addr;
  logic        no_mem;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .fetch_i(fetch), .mode_i(mode),
    .base_sel_i(base_sel), .idx_sel_i(idx_sel), .ptr_sel_i(ptr_sel),
    .bx_i(bx), .bp_i(bp), .si_i(si), .di_i(di), .disp_i(disp),
    .ovr_en_i(ovr_en), .ovr_sel_i(ovr_sel),
    .cs_i(cs), .ds_i(ds), .ss_i(ss), .es_i(es), .ip_i(ip),
    .addr_o(addr), .no_mem_o(no_mem)
  );

  task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
    end
  endtask

  function automatic logic exp_no_mem();
    return !fetch && (mode == 3'd0 || mode == 3'd1 || mode == 3'd7);
  endfunction

  function automatic logic [19:0] exp_addr();
    logic [15:0] seg, ofs, base, idx, ptr;
    base = base_sel ? bp : bx;
    idx  = idx_sel ? di : si;
    ptr  = (ptr_sel == 2'b01) ? si : (ptr_sel == 2'b10) ? di : bx;
    if (fetch) return ({4'h0, cs} << 4) + {4'h0, ip};
    case (mode)
      3'd2: ofs = disp;
      3'd3: ofs = ptr;
      3'd4: ofs = 16'(base + disp);
      3'd5: ofs = 16'(idx + disp);
      default: ofs = 16'(base + idx + disp);
    endcase
    if (ovr_en)
      seg = (ovr_sel == 2'd0) ? es : (ovr_sel == 2'd1) ? cs : (ovr_sel == 2'd2) ? ss : ds;
    else if (base_sel && (mode == 3'd4 || mode == 3'd6))
      seg = ss;
    else
      seg = ds;
    return 20'(({4'h0, seg} << 4) + {4'h0, ofs});
  endfunction

  // drive at negedge, sample 1 ns after the following posedge
  task automatic step(string tag);
    logic [19:0] ea;
    logic        en;
    ea = exp_addr();
    en = exp_no_mem();
    @(posedge clk);
    #1;
    check({tag, " no_mem"}, {19'd0, no_mem}, {19'd0, en});
    if (!en) check({tag, " addr"}, addr, ea);
    @(negedge clk);
  endtask

  task automatic clear();
    fetch = 0; mode = 3'd2; base_sel = 0; idx_sel = 0; ptr_sel = 0;
    bx = 16'h0000; bp = 0; si = 0; di = 0; disp = 0; ovr_en = 0; ovr_sel = 0;
    cs = 16'h1000; ds = 16'h2000; ss = 16'h3000; es = 16'h4000; ip = 16'h0000;
  endtask

  initial begin
    void'($urandom(32'd20240601));
    clear();
    repeat (3) @(negedge clk);
    check("R12 reset addr", addr, 20'h0);
    check("R12 reset no_mem", {19'd0, no_mem}, 20'h1);
    rst_n = 1'b1;
    @(negedge clk);

    fetch = 1; cs = 16'hFF59; ip = 16'hFFFF;
    step("R2 wrap fetch");
    check("R2 literal", addr, 20'h0F58F);
    clear(); fetch = 1; ip = 16'h0123; mode = 3'd0; ovr_en = 1; ovr_sel = 2'd0;
    step("R3 fetch ignores mode/override");
    check("R3 literal", addr, 20'h10123);
    clear(); disp = 16'h0042;
    step("R4 direct");
    check("R4 literal", addr, 20'h20042);
    clear(); mode = 3'd3; bx = 16'h0011; si = 16'h0022; di = 16'h0033;
    for (int p = 0; p < 4; p++) begin
      ptr_sel = 2'(p);
      step("R5 reg-indirect");
    end
    clear(); mode = 3'd4; base_sel = 1; bp = 16'h0010; disp = 16'h0002;
    step("R6 BP based");
    check("R6 literal", addr, 20'h30012);
    base_sel = 0; bx = 16'h0010;
    step("R6 BX based");
    clear(); mode = 3'd5; idx_sel = 1; di = 16'h0100; disp = 16'hFFFF;
    step("R7 indexed DI");
    check("R7 literal", addr, 20'h200FF);
    clear(); mode = 3'd6; base_sel = 1; bp = 16'h0100; si = 16'h0020; disp = 16'h0003;
    step("R8 based-indexed BP");
    check("R8 literal", addr, 20'h30123);
    clear(); mode = 3'd6; bx = 16'hFFF0; si = 16'h0020;
    step("R9 offset wrap");
    check("R9 literal", addr, 20'h20010);
    clear(); ds = 16'hFFFF; disp = 16'hFFFF;
    step("R1 address wrap");
    check("R1 literal", addr, 20'h0FFEF);
    clear(); mode = 3'd4; base_sel = 1; ovr_en = 1;
    for (int s = 0; s < 4; s++) begin
      ovr_sel = 2'(s);
      step("R10 override");
    end
    clear();
    for (int m = 0; m < 2; m++) begin
      mode = 3'(m);
      step("R11 no-memory mode");
    end
    mode = 3'd7;
    step("R11 reserved mode");

    for (int n = 0; n < 400; n++) begin
      fetch = ($urandom_range(0, 7) == 0);
      mode = 3'($urandom_range(0, 7));
      base_sel = 1'($urandom); idx_sel = 1'($urandom); ptr_sel = 2'($urandom);
      bx = 16'($urandom); bp = 16'($urandom); si = 16'($urandom); di = 16'($urandom);
      disp = 16'($urandom); ovr_en = 1'($urandom); ovr_sel = 2'($urandom);
      cs = 16'($urandom); ds = 16'($urandom); ss = 16'($urandom); es = 16'($urandom);
      ip = 16'($urandom);
      step("R1 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule